// File: doc/BRIEF.md
# Random Generator Control and Recovery

This block is the register front end and sequencing logic of a true random number generator. Software reaches it over a small word-addressed bus with separate read and write strobes and three registers: control (word address 0), status (word address 1) and data (word address 2). A 32-bit LFSR takes the place of the physical noise source. Two test inputs let a bench raise a seed fault or a clock fault at any moment.

Configuration fields (clock-fault detection enable and the divider exponent) are taken only when the same write also sets the conditional-reset bit. Releasing that bit starts an internal restart of fixed length. Data ready rises once a fresh word has been assembled. A seed fault halts generation and forces data reads to return zero. With automatic recovery enabled, the block restarts itself after a seed fault. It then leaves a sticky interrupt flag for software to acknowledge.

Top module: `trng_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read 0.
- R2: Writing control with the enable bit (bit 2) set makes data ready (status bit 0) rise exactly WORD_TICKS generator ticks after that write. A read of the data register (address 2) clears data ready until the next word is assembled.
- R3: Each data word read while no seed fault is present is nonzero and differs from the previous such word.
- R4: The clock-fault detect enable (control bit 5) and the divider exponent (control bits 19:16) change only on a control write that has the conditional-reset bit (bit 30) set. Other control writes leave them unchanged.
- R5: Control bit 30 reads 1 from the write that sets it until RST_TICKS generator ticks after the write that clears it. It then reads 0.
- R6: Data ready stays 0 while an internal restart is running.
- R7: Writing 1 to control bit 31 locks the configuration until reset. Bit 31 then reads 1, and later conditional-reset writes do not change bits 5 or 19:16.
- R8: A seed fault while enabled sets status bit 2 (seed fault present) and status bit 6 (seed fault interrupt), clears data ready, and makes data register reads return 0.
- R9: With automatic recovery, a seed fault starts an internal restart (bit 30 reads 1). When it ends, status bit 2 clears and generation resumes, while bit 6 stays set. Writing 1 to an interrupt bit leaves it unchanged, and writing 0 clears it.
- R10: With clock-fault detection captured as enabled, status bit 1 follows the clock-fault input one cycle later and status bit 5 latches until written 0. With detection disabled, neither bit sets.
- R11: One generator tick occurs every 2^exponent clock cycles, counted from the last control write. Restart and word assembly times scale with it.
- R12: Clearing the enable bit drops data ready at once and leaves the captured configuration readable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; a data read clears data ready |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| inj_seed_err | input | 1 | Test input: a high cycle raises a seed fault |
| inj_clk_err | input | 1 | Test input: level indicating a clock fault |

## Verification
The embedded assertions check the cycle-level invariants on every clock. Data ready is never high during a restart or while a seed fault is present. A data read always drops data ready. The lock never falls. The configuration moves only on a conditional-reset write. A restart never ends before a tick. Only the bench scenarios can show the exact tick counts to data ready and to restart completion under two divider settings. The same holds for the zero data word during a seed fault, the sticky versus current fault flags and the write-zero acknowledge. The bench also shows that lock and disable leave the configuration intact.

// File: rtl/trng_pkg.sv
`timescale 1ns/1ps
package trng_pkg;
    localparam int ADDR_W = 2;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    // control fields
    localparam int C_EN     = 2;
    localparam int C_CED    = 5;
    localparam int C_DIV_LO = 16;
    localparam int C_RST    = 30;
    localparam int C_LOCK   = 31;

    // status fields
    localparam int S_RDY  = 0;
    localparam int S_CCUR = 1;
    localparam int S_SCUR = 2;
    localparam int S_CIRQ = 5;
    localparam int S_SIRQ = 6;
endpackage

// File: rtl/trng_lfsr.sv
`timescale 1ns/1ps
module trng_lfsr #(
    parameter int          W     = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) st_d = (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/trng_prescaler.sv
`timescale 1ns/1ps
module trng_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, mask;

    always_comb begin
        mask   = (CNT_W'(1) << exp_i) - CNT_W'(1);
        tick_o = !clr_i && (cnt_q == mask);
        cnt_d  = cnt_q + CNT_W'(1);
        if (clr_i || tick_o) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/trng_ctrl.sv
`timescale 1ns/1ps
module trng_ctrl
    import trng_pkg::*;
#(
    parameter int DIV_W        = 4,
    parameter int WORD_TICKS   = 4,
    parameter int RST_TICKS    = 16,
    parameter bit AUTO_RECOVER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              inj_seed_err,
    input  logic              inj_clk_err
);
    localparam int WCNT_W = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1;
    localparam int RCNT_W = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;

    typedef struct packed {
        logic              en;
        logic              ced;
        logic              lock;
        logic              swrst;
        logic              rst_act;
        logic              secs;
        logic              seis;
        logic              cecs;
        logic              ceis;
        logic              drdy;
        logic [DIV_W-1:0]  div;
        logic [RCNT_W-1:0] rcnt;
        logic [WCNT_W-1:0] wcnt;
        logic [BUS_W-1:0]  data;
    } state_t;

    state_t d, q;
    logic   tick, running, wr_ctrl, wr_stat, rd_data;
    logic [BUS_W-1:0] word;
    logic   unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign rd_data = bus_rd && (bus_addr == A_DATA);
    assign running = q.en && !q.rst_act && !q.secs && !q.drdy;

    trng_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr_i(wr_ctrl), .exp_i(q.div), .tick_o(tick)
    );

    trng_lfsr #(.W(BUS_W)) u_src (
        .clk(clk), .rst_n(rst_n), .step_i(running && tick), .state_o(word)
    );

    always_comb begin
        d = q;
        // internal restart countdown, held while software keeps bit 30 set
        if (q.rst_act && !q.swrst && tick) begin
            if (q.rcnt == RCNT_W'(RST_TICKS - 1)) begin
                d.rst_act = 1'b0;
                d.rcnt    = '0;
                d.secs    = 1'b0;
            end else begin
                d.rcnt = q.rcnt + RCNT_W'(1);
            end
        end
        // word assembly
        if (running && tick) begin
            if (q.wcnt == WCNT_W'(WORD_TICKS - 1)) begin
                d.data = word;
                d.drdy = 1'b1;
                d.wcnt = '0;
            end else begin
                d.wcnt = q.wcnt + WCNT_W'(1);
            end
        end
        if (rd_data) d.drdy = 1'b0;
        // interrupt acknowledge: a 0 clears, a 1 keeps
        if (wr_stat) begin
            d.seis = q.seis & bus_wdata[S_SIRQ];
            d.ceis = q.ceis & bus_wdata[S_CIRQ];
        end
        if (wr_ctrl) begin
            d.en    = bus_wdata[C_EN];
            d.lock  = q.lock | bus_wdata[C_LOCK];
            d.swrst = bus_wdata[C_RST];
            if (!bus_wdata[C_EN]) begin
                d.drdy = 1'b0;
                d.wcnt = '0;
            end
            if (bus_wdata[C_RST]) begin
                d.rst_act = 1'b1;
                d.rcnt    = '0;
                d.drdy    = 1'b0;
                d.wcnt    = '0;
                if (!q.lock) begin
                    d.ced = bus_wdata[C_CED];
                    d.div = bus_wdata[C_DIV_LO +: DIV_W];
                end
            end
        end
        if (inj_seed_err && q.en && !q.secs) begin
            d.secs = 1'b1;
            d.seis = 1'b1;
            d.drdy = 1'b0;
            d.wcnt = '0;
            if (AUTO_RECOVER) begin
                d.rst_act = 1'b1;
                d.rcnt    = '0;
            end
        end
        d.cecs = q.ced & inj_clk_err;
        if (d.cecs) d.ceis = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[C_EN]               = q.en;
                bus_rdata[C_CED]              = q.ced;
                bus_rdata[C_DIV_LO +: DIV_W]  = q.div;
                bus_rdata[C_RST]              = q.swrst | q.rst_act;
                bus_rdata[C_LOCK]             = q.lock;
            end
            A_STAT: begin
                bus_rdata[S_RDY]  = q.drdy;
                bus_rdata[S_CCUR] = q.cecs;
                bus_rdata[S_SCUR] = q.secs;
                bus_rdata[S_CIRQ] = q.ceis;
                bus_rdata[S_SIRQ] = q.seis;
            end
            A_DATA:  bus_rdata = q.secs ? '0 : q.data;
            default: bus_rdata = '0;
        endcase
    end

    // R2: a data read always drops data ready
    a_r2_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && q.drdy) |=> !q.drdy);
    // R4: configuration moves only on an unlocked conditional-reset write
    a_r4_config_only_on_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_ctrl && bus_wdata[C_RST]) || q.lock) |=> ($stable(q.div) && $stable(q.ced)));
    // R5: a released restart cannot finish without a generator tick
    a_r5_busy_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rst_act && !q.swrst && !tick) |=> q.rst_act);
    // R6: no data ready during a restart
    a_r6_no_ready_in_restart: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_act |-> !q.drdy);
    // R7: lock is sticky
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> q.lock);
    // R8: a new seed fault carries its interrupt, and data ready is down
    a_r8_seed_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.secs) |-> q.seis);
    a_r8_no_ready_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        q.secs |-> !q.drdy);
endmodule

// File: tb/trng_ctrl_tb.sv
`timescale 1ns/1ps
module trng_ctrl_tb;
    import trng_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              inj_seed_err = 1'b0;
    logic              inj_clk_err = 1'b0;

    always #2 clk = ~clk;

    trng_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .inj_seed_err(inj_seed_err), .inj_clk_err(inj_clk_err)
    );

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        bit          nz;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] last_word = '0;

    // driver tasks: called at a falling edge, return one falling edge later
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                      input logic [31:0] m, input string t);
        exp_t it;
        it.exp = e; it.mask = m; it.nz = 1'b0; it.tag = t;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_word(input string t);
        exp_t it;
        it.exp = '0; it.mask = '0; it.nz = 1'b1; it.tag = t;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = A_DATA;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the expected item for each read, samples mid low phase
    always begin
        @(negedge clk);
        #1;
        if (bus_rd) begin
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                checks++;
                if (it.nz) begin
                    if (bus_rdata == '0 || bus_rdata == last_word) begin
                        errors++;
                        $display("FAIL %s: actual %h expected nonzero and not %h",
                                 it.tag, bus_rdata, last_word);
                    end
                    last_word = bus_rdata;
                end else if ((bus_rdata & it.mask) != (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h (mask %h)",
                             it.tag, bus_rdata & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        rd(A_CTRL, 32'h0, 32'hFFFF_FFFF, "R1 control after reset");
        rd(A_STAT, 32'h0, 32'hFFFF_FFFF, "R1 status after reset");

        // R10: detection off, clock fault ignored
        inj_clk_err = 1'b1;
        idle(1);
        rd(A_STAT, 32'h0, 32'h22, "R10 no flag with detection off");
        inj_clk_err = 1'b0;

        // R2: ready exactly WORD_TICKS ticks after enable (div 0)
        wr(A_CTRL, 32'h0000_0004);
        rd(A_STAT, 32'h0, 32'h1, "R2 ready low after enable");
        idle(2);
        rd(A_STAT, 32'h0, 32'h1, "R2 ready low one tick early");
        rd(A_STAT, 32'h1, 32'h1, "R2 ready high on time");
        rd_word("R3 first word");
        rd(A_STAT, 32'h0, 32'h1, "R2 data read clears ready");
        idle(6);
        rd_word("R3 second word");

        // R4/R5/R6: capture through conditional reset, then release
        wr(A_CTRL, 32'h4000_0024);
        rd(A_CTRL, 32'h4000_0024, 32'hFFFF_FFFF, "R5 bit held while set");
        rd(A_STAT, 32'h0, 32'h1, "R6 no ready in restart");
        wr(A_CTRL, 32'h0000_0024);
        rd(A_CTRL, 32'h4000_0024, 32'hFFFF_FFFF, "R5 busy after release");
        idle(13);
        rd(A_CTRL, 32'h4000_0024, 32'hFFFF_FFFF, "R5 busy at tick 14");
        rd(A_CTRL, 32'h4000_0024, 32'hFFFF_FFFF, "R5 busy at tick 15");
        rd(A_CTRL, 32'h0000_0024, 32'hFFFF_FFFF, "R5 done at tick 16");

        // R4: config without bit 30 is ignored
        wr(A_CTRL, 32'h000F_0004);
        rd(A_CTRL, 32'h0000_0024, 32'hFFFF_FFFF, "R4 config ignored");

        // R10: detection on
        inj_clk_err = 1'b1;
        idle(1);
        rd(A_STAT, 32'h22, 32'h22, "R10 current and sticky set");
        inj_clk_err = 1'b0;
        idle(1);
        rd(A_STAT, 32'h20, 32'h22, "R10 sticky after fault gone");
        wr(A_STAT, 32'h0000_0020);
        rd(A_STAT, 32'h20, 32'h20, "R9 write one keeps interrupt");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h0, 32'h20, "R10 write zero clears");

        // R8/R9: seed fault and automatic recovery
        idle(8);
        inj_seed_err = 1'b1;
        idle(1);
        inj_seed_err = 1'b0;
        rd(A_STAT, 32'h44, 32'h47, "R8 both seed flags, ready low");
        rd(A_DATA, 32'h0, 32'hFFFF_FFFF, "R8 data reads zero");
        rd(A_CTRL, 32'h4000_0000, 32'h4000_0000, "R9 auto restart busy");
        idle(20);
        rd(A_STAT, 32'h40, 32'h46, "R9 current clear, interrupt kept");
        wr(A_STAT, 32'h0000_0040);
        rd(A_STAT, 32'h40, 32'h40, "R9 write one keeps seed interrupt");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h0, 32'h40, "R9 write zero clears seed interrupt");
        idle(8);
        rd(A_STAT, 32'h1, 32'h1, "R9 generation resumed");
        rd_word("R3 word after recovery");

        // R12: disable
        idle(8);
        rd(A_STAT, 32'h1, 32'h1, "R12 ready before disable");
        wr(A_CTRL, 32'h0);
        rd(A_STAT, 32'h0, 32'h1, "R12 ready dropped");
        rd(A_CTRL, 32'h0000_0020, 32'hFFFF_FFFF, "R12 config kept");

        // R11: divider exponent 1 doubles restart and assembly times
        wr(A_CTRL, 32'h4001_0004);
        wr(A_CTRL, 32'h0000_0004);
        idle(39);
        rd(A_STAT, 32'h0, 32'h1, "R11 ready low at cycle 39");
        rd(A_STAT, 32'h1, 32'h1, "R11 ready high at cycle 40");
        rd(A_CTRL, 32'h0001_0004, 32'hFFFF_FFFF, "R11 divider captured");

        // R7: lock
        wr(A_CTRL, 32'hC000_0024);
        wr(A_CTRL, 32'h0000_0004);
        idle(40);
        wr(A_CTRL, 32'h4005_0004);
        wr(A_CTRL, 32'h0000_0004);
        idle(40);
        rd(A_CTRL, 32'h8000_0024, 32'hFFFF_FFFF, "R7 locked config unchanged");

        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule